// File: doc/BRIEF.md
# Interval Timebase Timer

A free-running binary counter advances once per oscillator clock and sets an overflow flag each time a selected counter bit carries out. Four tap positions are unevenly spaced: 2^12, 2^14, 2^16 and 2^19 clocks. An 8-bit control byte selects the tap, holds the flag and an interrupt enable, and carries a write-only strobe that restarts the counter. The byte sits in the upper half of a 16-bit register word. Port bit n corresponds to word bit n+8.

Software polls or enables the flag, services the event and clears the flag by writing 0 to it. The interrupt line is a registered AND of the flag and the enable. It stays high until the flag is cleared. Address decoding is done outside the block. A write strobe and a write byte reach the block already qualified.

Top module: `ivl_timer`

## Requirements
- R1: Select field bits 9:8 (port bits 1:0) choose the overflow period of the 19-bit free-running counter. Code 00 gives 2^TAP_SEL0 clocks (12), 01 gives 2^TAP_SEL1 (14), 10 gives 2^TAP_SEL2 (16) and 11 gives 2^TAP_SEL3 (19). After a counter restart, the first overflow occurs on the 2^tap-th rising edge.
- R2: The overflow flag, word bit 11 (port bit 3), goes to 1 on the edge at which the counter bits below the selected tap wrap to zero.
- R3: Writing 0 to bit 11 clears the flag. Writing 1 to it leaves the flag unchanged.
- R4: Word bit 12 (port bit 4) is the interrupt enable. `irq` is 1 exactly one edge after flag and enable are both 1. It returns to 0 one edge after either of them is 0.
- R5: Word bit 10 (port bit 2) is write-only. Writing 0 restarts the counter from zero and clears the flag, and no overflow is taken on that edge. Writing 1 has no effect. The bit always reads as 1.
- R6: Word bit 15 (port bit 7) always reads 1. Word bits 14:13 (port bits 6:5) always read 0, and writes to them are ignored.
- R7: After reset the read byte is 0x84 (enable 0, flag 0, select 00), and `irq` is 0.
- R8: If an overflow and a flag-clear write fall on the same edge, the flag ends up set.
- R9: Changing the select field does not restart the counter. The next overflow comes from the newly selected tap at the counter's current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write (word bits 15:8) |
| rd_data | output | 8 | Current control byte as read back |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The counter is not visible at the ports. A wrong count or a wrong tap shows up only as a flag that rises on the wrong edge. The bench therefore restarts the counter and checks the flag on the edges just before and exactly at 2^tap. A one-off error is caught at the first overflow after a restart.

A flag that fails to clear, or one that is set twice, shows up on the next read of the byte. An interrupt path that is not registered shows `irq` one edge too early. The bench uses narrow taps so that every code, including the widest one, is reached within a few thousand cycles.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  localparam int unsigned BIT_SEL_LO = 0;
  localparam int unsigned BIT_CLR    = 2;
  localparam int unsigned BIT_FLAG   = 3;
  localparam int unsigned BIT_IE     = 4;

  function automatic logic [31:0] low_mask(input int unsigned width);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < width) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [7:0] pack_read(input logic ie, input logic flag,
                                           input logic [1:0] sel);
    return {1'b1, 2'b00, ie, flag, 1'b1, sel};
  endfunction

endpackage

// File: rtl/ivl_counter.sv
module ivl_counter
  import ivl_timer_pkg::*;
#(
  parameter int unsigned TAP_A = 12,
  parameter int unsigned TAP_B = 14,
  parameter int unsigned TAP_C = 16,
  parameter int unsigned TAP_D = 19,
  localparam int unsigned CNT_W = TAP_D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_clr,
  input  logic [1:0] sel,
  output logic       ovf_evt
);

  localparam int unsigned TAPV [4] = '{TAP_A, TAP_B, TAP_C, TAP_D};

  logic [CNT_W-1:0] cnt;
  logic [3:0]       tap_hit;
  logic [31:0]      cnt_ext;

  assign cnt_ext = 32'(cnt);

  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam logic [31:0] MASK = low_mask(TAPV[g]);
    assign tap_hit[g] = ((cnt_ext & MASK) == MASK);
  end

  assign ovf_evt = tap_hit[sel] & ~cnt_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_clr) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt == '0));
  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt == $past(cnt) + 1'b1));
  p_wrap_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ((32'(cnt) & low_mask(TAPV[$past(sel)])) == '0));

endmodule

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
  import ivl_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       ovf_evt,
  output logic       cnt_clr,
  output logic       flag,
  output logic       ie,
  output logic [1:0] sel,
  output logic [7:0] rd_data
);

  logic flag_clr;

  assign cnt_clr  = wr_en & ~wr_data[BIT_CLR];
  assign flag_clr = wr_en & (~wr_data[BIT_FLAG] | ~wr_data[BIT_CLR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie  <= 1'b0;
      sel <= 2'b00;
    end else if (wr_en) begin
      ie  <= wr_data[BIT_IE];
      sel <= wr_data[BIT_SEL_LO +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (ovf_evt)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assign rd_data = pack_read(ie, flag, sel);

  p_ovf_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag);
  p_clear_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_evt) |=> !flag);
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_evt && !flag_clr) |=> $stable(flag));
  p_ovf_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && flag_clr) |=> flag);

endmodule

// File: rtl/ivl_irq.sv
module ivl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic ie,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= flag & ie;
  end

  p_irq_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ie) |=> irq);
  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag && ie) |=> !irq);

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int unsigned TAP_SEL0 = 12,
  parameter int unsigned TAP_SEL1 = 14,
  parameter int unsigned TAP_SEL2 = 16,
  parameter int unsigned TAP_SEL3 = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);

  logic       cnt_clr;
  logic       ovf_evt;
  logic       flag;
  logic       ie;
  logic [1:0] sel;

  ivl_counter #(
    .TAP_A(TAP_SEL0), .TAP_B(TAP_SEL1), .TAP_C(TAP_SEL2), .TAP_D(TAP_SEL3)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .sel(sel), .ovf_evt(ovf_evt)
  );

  ivl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_evt(ovf_evt), .cnt_clr(cnt_clr), .flag(flag), .ie(ie),
    .sel(sel), .rd_data(rd_data)
  );

  ivl_irq u_irq (
    .clk(clk), .rst_n(rst_n), .flag(flag), .ie(ie), .irq(irq)
  );

  p_reserved_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !rd_data[6] && !rd_data[5] && rd_data[2]));

endmodule

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;

  localparam int unsigned T0 = 4;
  localparam int unsigned T1 = 6;
  localparam int unsigned T2 = 8;
  localparam int unsigned T3 = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ivl_timer #(.TAP_SEL0(T0), .TAP_SEL1(T1), .TAP_SEL2(T2), .TAP_SEL3(T3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge consumed; returns at the following negedge
  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R7 reset byte", rd_data, 8'h84);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_period(input logic [1:0] s, input int unsigned t);
    wr(8'h08 | {6'b0, s});  // restart counter, flag write 1
    edges((1 << t) - 1);
    chk("R1 flag before period", {7'b0, rd_data[3]}, 8'h00);
    edges(1);
    chk("R2 flag at period", {7'b0, rd_data[3]}, 8'h01);
  endtask

  task automatic t_flag_write;
    t_period(2'b00, T0);
    wr(8'h0C);
    chk("R3 write 1 keeps flag", rd_data, 8'h8C);
    wr(8'h04);
    chk("R3 write 0 clears flag", rd_data, 8'h84);
  endtask

  task automatic t_clear_strobe;
    t_period(2'b00, T0);
    wr(8'h08);
    chk("R5 strobe clears flag, reads 1", rd_data, 8'h84);
    edges((1 << T0) - 1);
    chk("R5 restart no early flag", {7'b0, rd_data[3]}, 8'h00);
    edges(1);
    chk("R5 restart period", {7'b0, rd_data[3]}, 8'h01);
  endtask

  task automatic t_irq;
    wr(8'h18);
    edges((1 << T0) - 1);
    chk("R4 irq low before flag", {7'b0, irq}, 8'h00);
    edges(1);
    chk("R4 irq one edge after flag", {7'b0, irq}, 8'h00);
    edges(1);
    chk("R4 irq asserted", {7'b0, irq}, 8'h01);
    wr(8'h14);
    chk("R4 irq held on clear edge", {7'b0, irq}, 8'h01);
    edges(1);
    chk("R4 irq drops after clear", {7'b0, irq}, 8'h00);
    wr(8'h08);
    edges(1 << T0);
    chk("R4 flag set, enable off", rd_data, 8'h8C);
    edges(3);
    chk("R4 irq blocked", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_unused;
    wr(8'h60);
    chk("R6 unused ignored", rd_data, 8'h84);
    wr(8'h7F);
    chk("R6 unused and reserved", rd_data, 8'h97);
    wr(8'h00);
  endtask

  task automatic t_collide;
    wr(8'h08);
    edges((1 << T0) - 1);
    wr(8'h04);
    chk("R8 overflow beats clear", {7'b0, rd_data[3]}, 8'h01);
    wr(8'h04);
    chk("R8 later clear works", {7'b0, rd_data[3]}, 8'h00);
  endtask

  task automatic t_switch;
    wr(8'h09);
    edges(20);
    wr(8'h0C);  // lands on edge 21, count keeps running
    edges(10);
    chk("R9 no flag at count 31", {7'b0, rd_data[3]}, 8'h00);
    edges(1);
    chk("R9 flag at count 32", {7'b0, rd_data[3]}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_period(2'b00, T0);
    t_period(2'b01, T1);
    t_period(2'b10, T2);
    t_period(2'b11, T3);
    t_flag_write();
    t_clear_strobe();
    t_irq();
    t_unused();
    t_collide();
    t_switch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule